// File: doc/BRIEF.md
# Thermometer-Coded Address Match Comparator

This block decides whether an address presented on a 12-bit bus falls on a board's assigned slot, so that it can serve as a chip select. Software does not program the slot. A 4-bit code, normally tied to fixed levels on the board, sets a split point in the address. Every address bit below the split must be 0 and every bit above it must be 1. The block expands the code into one expected level per address bit. It compares the bus against those levels, reduces the result to one bit, and drives an active-low match output.

The block has no clock and no state. The output is a pure function of the address, the code and an active-low enable. While the enable is deasserted, the output is held at its inactive level. Codes 12 to 14 are not meant for normal use. They still decode to fixed patterns that do not follow the thermometer order, so any value on the code pins gives a defined result. Address bit A(k) is carried on `addr[k-1]`.

Top module: `thermo_addr_match`

## Requirements
- R1: With `en_n` = 0 and `code` = n for n in 0..11, `match_n` is 0 exactly when `addr[k-1]` = 0 for k ≤ n and `addr[k-1]` = 1 for k > n.
- R2: With `code` = 7 and `en_n` = 0, `match_n` is 0 for `addr` = 12'hF80 (A1–A7 low, A8–A12 high).
- R3: With `code` = 12 and `en_n` = 0, the only matching address is A1–A8 low, A9–A11 high, A12 low (`addr` = 12'h700).
- R4: With `code` = 13 the only match is `addr` = 12'h600 (A1–A9 low, A10–A11 high, A12 low). With `code` = 14 the only match is `addr` = 12'h400 (A1–A10 low, A11 high, A12 low).
- R5: With `code` = 15 and `en_n` = 0, the only matching address is all twelve bits low (`addr` = 12'h000).
- R6: Starting from the matching address of any code with `en_n` = 0, inverting any single address bit makes `match_n` = 1.
- R7: While `en_n` = 1, `match_n` = 1 for every `addr` and `code`, including each code's matching address.
- R8: `match_n` depends only on the present `addr`, `code` and `en_n`. The same inputs give the same output whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 12 | Address bus; `addr[k-1]` carries A(k) |
| code | input | 4 | Preset split code, normally static |
| en_n | input | 1 | Active-low enable; 1 forces `match_n` high |
| match_n | output | 1 | Active-low match indication |

## Verification
Every one of the 16 codes is applied with its exact matching address. This separates a correct split point from one that is off by a bit, and it separates the irregular mapping for codes 12 to 14 from a plain thermometer. Flipping each of the twelve bits in turn, from each matching address, shows that no bit is left out of the compare. The same matches repeated with the enable deasserted show that the gating overrides a true match. Random address, code and enable triples, replayed in varying orders, show that the output follows only the present inputs.

// File: rtl/addr_cmp_pkg.sv
package addr_cmp_pkg;
  localparam int unsigned ADDR_W_DEF = 12;
  localparam int unsigned CODE_W_DEF = 4;
endpackage

// File: rtl/code_level_decoder.sv
module code_level_decoder #(
  parameter int unsigned ADDR_W = addr_cmp_pkg::ADDR_W_DEF,
  parameter int unsigned CODE_W = addr_cmp_pkg::CODE_W_DEF
) (
  input  logic [CODE_W-1:0] code,
  output logic [ADDR_W-1:0] exp_lvl
);
  // Codes at or above ADDR_W reuse the bits just below the top one, counting again from the top of the thermometer.
  localparam int unsigned NCODES  = 2 ** CODE_W;
  localparam int unsigned WRAP_LO = 2 * ADDR_W - NCODES;

  logic [31:0] code_w;
  assign code_w = 32'(code);

  for (genvar i = 1; i <= ADDR_W; i++) begin : g_bit
    if (i <= WRAP_LO) begin : g_thermo
      assign exp_lvl[i-1] = !(code_w >= 32'(i));
    end else if (i < ADDR_W) begin : g_wrap
      assign exp_lvl[i-1] = !(((code_w >= 32'(i)) && (code_w < 32'(ADDR_W)))
                              || (code_w >= 32'(ADDR_W + i - WRAP_LO)));
    end else begin : g_top
      assign exp_lvl[i-1] = !(code_w >= 32'(ADDR_W));
    end
  end

  always_comb begin
    if (code == '0) p_code0_all_high_r1: assert (exp_lvl == '1);
    if (code == '1) p_code_max_all_low_r5: assert (exp_lvl == '0);
  end
endmodule

// File: rtl/level_compare.sv
module level_compare #(
  parameter int unsigned W = addr_cmp_pkg::ADDR_W_DEF
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic         differ
);
  logic [W-1:0] bit_diff;
  assign bit_diff = lhs ^ rhs;
  assign differ   = |bit_diff;
endmodule

// File: rtl/thermo_addr_match.sv
module thermo_addr_match #(
  parameter int unsigned ADDR_W = addr_cmp_pkg::ADDR_W_DEF,
  parameter int unsigned CODE_W = addr_cmp_pkg::CODE_W_DEF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] code,
  input  logic              en_n,
  output logic              match_n
);
  logic [ADDR_W-1:0] exp_lvl;
  logic              differ;

  code_level_decoder #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_dec (
    .code    (code),
    .exp_lvl (exp_lvl)
  );

  level_compare #(.W(ADDR_W)) u_cmp (
    .lhs    (addr),
    .rhs    (exp_lvl),
    .differ (differ)
  );

  assign match_n = en_n | differ;

  always_comb begin
    if (en_n) p_disabled_high_r7: assert (match_n);
    if (!match_n) p_low_only_exact_r6: assert (addr == exp_lvl);
  end
endmodule

// File: tb/thermo_addr_match_tb.sv
module thermo_addr_match_tb;
  logic        clk = 1'b0;
  logic [11:0] addr = '0;
  logic [3:0]  code = '0;
  logic        en_n = 1'b1;
  logic        match_n;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  thermo_addr_match u_dut (.addr(addr), .code(code), .en_n(en_n), .match_n(match_n));

  // Expected level of A(k) for a code, taken from the requirement tables.
  function automatic bit want_level(input int p, input int k);
    case (k)
      9:  return !(p inside {9, 10, 11, 13, 14, 15});
      10: return !(p inside {10, 11, 14, 15});
      11: return !(p inside {11, 15});
      12: return !(p >= 12);
      default: return !(p >= k);
    endcase
  endfunction

  function automatic logic [11:0] match_addr(input int p);
    logic [11:0] a;
    for (int k = 1; k <= 12; k++) a[k-1] = want_level(p, k);
    return a;
  endfunction

  function automatic bit want_out(input logic [11:0] a, input int p, input bit e);
    if (e) return 1'b1;
    return a != match_addr(p);
  endfunction

  task automatic apply(input logic [11:0] a, input int p, input bit e, input bit want, input string req);
    @(negedge clk);
    addr = a; code = 4'(p); en_n = e;
    @(posedge clk);
    #1;
    n_vec++;
    if (match_n !== want) begin
      n_bad++;
      $display("FAIL %s addr=%h code=%0d en_n=%0b got=%b exp=%b", req, a, p, e, match_n, want);
    end
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] ra;
    int rp;
    bit re;
    void'($urandom(32'd20240611));
    #1;
    if (match_n !== 1'b1) begin
      n_bad++;
      $display("FAIL R7 start got=%b exp=1", match_n);
    end
    n_vec++;
    // R2, R3, R4 and R5: fixed patterns.
    apply(12'hF80, 7, 1'b0, 1'b0, "R2");
    apply(12'h700, 12, 1'b0, 1'b0, "R3");
    apply(12'h600, 13, 1'b0, 1'b0, "R4");
    apply(12'h400, 14, 1'b0, 1'b0, "R4");
    apply(12'h000, 15, 1'b0, 1'b0, "R5");
    apply(12'hFFF, 12, 1'b0, 1'b1, "R3");
    apply(12'h800, 15, 1'b0, 1'b1, "R5");
    // R1: every code with its matching address, then R6 single-bit flips.
    for (int p = 0; p < 16; p++) begin
      apply(match_addr(p), p, 1'b0, 1'b0, "R1");
      for (int b = 0; b < 12; b++)
        apply(match_addr(p) ^ (12'h1 << b), p, 1'b0, 1'b1, "R6");
    end
    // R7: the enable overrides a true match.
    for (int p = 0; p < 16; p++)
      apply(match_addr(p), p, 1'b1, 1'b1, "R7");
    // R8: random triples, near-matches included, each replayed after other stimulus.
    for (int n = 0; n < 300; n++) begin
      rp = int'($urandom_range(15, 0));
      re = ($urandom_range(3, 0) == 0);
      ra = ($urandom_range(1, 0) == 1) ? match_addr(rp) : 12'($urandom());
      if ($urandom_range(3, 0) == 0) ra = ra ^ (12'h1 << $urandom_range(11, 0));
      apply(ra, rp, re, want_out(ra, rp, re), "R1");
      apply(~ra, 15 - rp, ~re, want_out(~ra, 15 - rp, ~re), "R8");
      apply(ra, rp, re, want_out(ra, rp, re), "R8");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule